// File: doc/BRIEF.md
# Timed-Unlock Division Select Register

This block is an 8-bit control register that holds the 4-bit select for a downstream system clock divider. It is built to stop a stray store from changing the clock rate. A plain write cannot change the select. Software must first store an exact key pattern. That store opens a short window, and the select may be written only while the window is open. The window closes by itself after a fixed number of cycles. Writing the key again does not change it.

The register sits on a simple bus made of a write strobe, write data and combinational read data, all clocked by the system clock. A static strap input picks the select value loaded at reset. When a select write is accepted, the divider receives the new value together with a single-cycle update strobe.

Top module: `divsel_lock_reg`

## Requirements
- R1: While reset is asserted and just after it, divSel is 4'b0011 if strapDiv8 is 1 and 4'b0000 if it is 0, and the unlock flag (rdData[7]) is 0.
- R2: rdData always equals {unlock flag, 3'b000, divSel}: the flag is in bit 7, the select is in bits 3..0, and bits 6..4 read as zero.
- R3: A write of exactly 8'h80 while the window is closed sets the unlock flag from the next cycle on.
- R4: A write with bit 7 set and any of bits 6..0 nonzero does not open the window.
- R5: When no select write arrives, the unlock flag stays high for exactly four cycles and then clears without any write.
- R6: Writing 8'h80 again while the window is open neither clears the flag nor restarts the four-cycle count.
- R7: A write with bit 7 at 0 during an open window loads wrData[3..0] into divSel on the next cycle, ignores wrData[6..4], and clears the unlock flag.
- R8: Any write made while the window is closed leaves divSel unchanged and produces no update strobe.
- R9: divSelUpd is high for exactly one cycle, in the first cycle that shows the new divSel, and only after an accepted select write.
- R10: After reset, any 4-bit select value can be loaded whatever the strap setting, including 4'b0000 when strapDiv8 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strapDiv8 | input | 1 | Static strap that selects the reset value of the division select |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data: unlock flag and current select |
| divSel | output | 4 | Current division select for the divider |
| divSelUpd | output | 1 | Single-cycle strobe that marks a new divSel value |

## Verification
The bench aims at the edges of the unlock window. It makes a select write in the fourth and last open cycle, where it must be taken, and one in the cycle just after, where it must be dropped. A counter that is off by one would accept the late write or refuse the valid one. It repeats the key inside the window: a design that restarts the timeout would take a write that comes too late, and one that toggles the flag would refuse a valid write. It also sends near-key patterns such as 8'h81, sends select bytes with the upper bits set, and loads 4'b0000 after a reset with the strap active. A wrong design would open on a partial match, leak bits 6..4 into the select, or keep the strap value.

// File: rtl/divsel_pkg.sv
package divsel_pkg;

  // Strobes passed from the unlock control to the select datapath.
  typedef struct packed {
    logic loadSel;   // accept wrData select field this cycle
    logic unlocked;  // window currently open
  } divsel_strobe_t;

endpackage

// File: rtl/divsel_ctrl.sv
module divsel_ctrl
  import divsel_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int WIN_CYC = 4,
  parameter int KEY_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output divsel_strobe_t    strobe
);

  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [DATA_W-1:0] KEY_PAT = DATA_W'(1) << KEY_BIT;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(WIN_CYC);

  logic             winOpen;
  logic [CNT_W-1:0] cyclesLeft;
  logic             keyHit;
  logic             selHit;

  // The key must match exactly: the enable bit set, all other bits clear.
  assign keyHit = wrEn && (wrData == KEY_PAT);
  assign selHit = wrEn && winOpen && !wrData[KEY_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen    <= 1'b0;
      cyclesLeft <= '0;
    end else if (selHit) begin
      winOpen    <= 1'b0;
      cyclesLeft <= '0;
    end else if (winOpen) begin
      // While the window is open, key writes are ignored: there is no restart.
      if (cyclesLeft == CNT_ONE) begin
        winOpen <= 1'b0;
      end
      cyclesLeft <= cyclesLeft - CNT_ONE;
    end else if (keyHit) begin
      winOpen    <= 1'b1;
      cyclesLeft <= CNT_FULL;
    end
  end

  always_comb begin
    strobe.loadSel  = selHit;
    strobe.unlocked = winOpen;
  end

endmodule

// File: rtl/divsel_data.sv
module divsel_data
  import divsel_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 4,
  parameter int          KEY_BIT   = 7,
  parameter int unsigned STRAP_SEL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapDiv8,
  input  logic [SEL_W-1:0]  selIn,
  input  divsel_strobe_t    strobe,
  output logic [SEL_W-1:0]  selQ,
  output logic              updQ,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [SEL_W-1:0] SEL_STRAP = SEL_W'(STRAP_SEL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= strapDiv8 ? SEL_STRAP : '0;
      updQ <= 1'b0;
    end else begin
      updQ <= strobe.loadSel;
      if (strobe.loadSel) begin
        selQ <= selIn;
      end
    end
  end

  always_comb begin
    rdData                = '0;
    rdData[SEL_W-1:0]     = selQ;
    rdData[KEY_BIT]       = strobe.unlocked;
  end

endmodule

// File: rtl/divsel_lock_reg.sv
module divsel_lock_reg
  import divsel_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          SEL_W     = 4,
  parameter int          WIN_CYC   = 4,
  parameter int          KEY_BIT   = 7,
  parameter int unsigned STRAP_SEL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapDiv8,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [SEL_W-1:0]  divSel,
  output logic              divSelUpd
);

  divsel_strobe_t strobe;

  divsel_ctrl #(
    .DATA_W (DATA_W),
    .WIN_CYC(WIN_CYC),
    .KEY_BIT(KEY_BIT)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrData(wrData),
    .strobe(strobe)
  );

  divsel_data #(
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .KEY_BIT  (KEY_BIT),
    .STRAP_SEL(STRAP_SEL)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strapDiv8(strapDiv8),
    .selIn    (wrData[SEL_W-1:0]),
    .strobe   (strobe),
    .selQ     (divSel),
    .updQ     (divSelUpd),
    .rdData   (rdData)
  );

endmodule

// File: rtl/divsel_lock_reg_chk.sv
module divsel_lock_reg_chk #(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  parameter int WIN_CYC = 4,
  parameter int KEY_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [SEL_W-1:0]  divSel,
  input logic              divSelUpd
);

  localparam logic [DATA_W-1:0] KEY_PAT = DATA_W'(1) << KEY_BIT;
  localparam int OPEN_W = $clog2(WIN_CYC + 2);

  // Number of earlier consecutive cycles in which the unlock flag was high.
  logic [OPEN_W-1:0] openRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                openRun <= '0;
    else if (rdData[KEY_BIT]) openRun <= openRun + OPEN_W'(1);
    else                      openRun <= '0;
  end

  a_r2_read_layout: assert property (@(posedge clk) disable iff (!rstN)
    rdData[KEY_BIT-1:SEL_W] == '0 && rdData[SEL_W-1:0] == divSel);

  a_r3_key_opens: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData == KEY_PAT && !rdData[KEY_BIT] |=> rdData[KEY_BIT]);

  a_r4_partial_key: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[KEY_BIT] && wrData != KEY_PAT && !rdData[KEY_BIT] |=> !rdData[KEY_BIT]);

  a_r5_window_limit: assert property (@(posedge clk) disable iff (!rstN)
    rdData[KEY_BIT] |-> openRun < OPEN_W'(WIN_CYC));

  a_r6_rekey_keeps: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData == KEY_PAT && rdData[KEY_BIT] && openRun < OPEN_W'(WIN_CYC - 1)
    |=> rdData[KEY_BIT]);

  a_r7_select_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrData[KEY_BIT] && rdData[KEY_BIT]
    |=> divSel == $past(wrData[SEL_W-1:0]) && divSelUpd && !rdData[KEY_BIT]);

  a_r8_closed_ignored: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !rdData[KEY_BIT] |=> $stable(divSel) && !divSelUpd);

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    divSelUpd |-> $past(wrEn && !wrData[KEY_BIT] && rdData[KEY_BIT]));

  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !divSelUpd |-> $stable(divSel));

endmodule

bind divsel_lock_reg divsel_lock_reg_chk #(
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .WIN_CYC(WIN_CYC),
  .KEY_BIT(KEY_BIT)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .divSel   (divSel),
  .divSelUpd(divSelUpd)
);

// File: tb/test_divsel_lock_reg.sv
module test_divsel_lock_reg;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapDiv8 = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [3:0] divSel;
  logic       divSelUpd;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state.
  int mOpen = 0;
  int mLeft = 0;
  int mSel  = 0;
  int mUpd  = 0;

  divsel_lock_reg i_divsel_lock_reg (
    .clk(clk), .rstN(rstN), .strapDiv8(strapDiv8), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .divSel(divSel), .divSelUpd(divSelUpd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOpen = 0; mLeft = 0; mUpd = 0;
      mSel  = strapDiv8 ? 3 : 0;
    end else begin
      mUpd = 0;
      if (mOpen != 0) begin
        if (wrEn && !wrData[7]) begin
          mSel = int'(wrData & 8'h0F);
          mOpen = 0;
          mUpd = 1;
        end else begin
          mLeft = mLeft - 1;
          if (mLeft == 0) mOpen = 0;
        end
      end else if (wrEn && wrData == 8'h80) begin
        mOpen = 1;
        mLeft = 4;
      end
    end
  end

  task automatic check(input string req);
    logic [7:0] expRd;
    expRd = 8'(mSel) | (mOpen != 0 ? 8'h80 : 8'h00);
    tests++;
    if (rdData !== expRd || divSel !== 4'(mSel) || divSelUpd !== (mUpd != 0)) begin
      fails++;
      $display("FAIL %s: rd=%h sel=%h upd=%b expected rd=%h sel=%h upd=%b",
               req, rdData, divSel, divSelUpd, expRd, 4'(mSel), (mUpd != 0));
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input string req);
    @(negedge clk);
    check(req);
    wrEn = we;
    wrData = d;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, req);
  endtask

  task automatic doReset(input logic s);
    @(negedge clk);
    wrEn = 1'b0;
    strapDiv8 = s;
    rstN = 1'b0;
    @(negedge clk);
    check("R1");
    @(negedge clk);
    check("R1");
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset(1'b0);
    idle(2, "R1");
    // R8: select write with window closed
    step(1'b1, 8'h05, "R8"); idle(2, "R8");
    // R3 + R7 + R9: key then select
    step(1'b1, 8'h80, "R3"); step(1'b1, 8'h07, "R7"); idle(3, "R9");
    // R4: partial key must not open
    step(1'b1, 8'h81, "R4"); step(1'b1, 8'h02, "R4"); idle(2, "R4");
    step(1'b1, 8'hFF, "R4"); step(1'b1, 8'h01, "R4"); idle(2, "R4");
    // R5: window lapses after four cycles
    step(1'b1, 8'h80, "R5"); idle(4, "R5"); step(1'b1, 8'h09, "R5"); idle(2, "R5");
    // R5: select in last open cycle still taken
    step(1'b1, 8'h80, "R5"); idle(3, "R5"); step(1'b1, 8'h0F, "R5"); idle(2, "R5");
    // R6: rekey inside window does not extend, does not clear
    step(1'b1, 8'h80, "R6"); step(1'b1, 8'h80, "R6"); step(1'b1, 8'h80, "R6");
    idle(1, "R6"); step(1'b1, 8'h0A, "R6"); idle(2, "R6");
    step(1'b1, 8'h80, "R6");
    for (int i = 0; i < 4; i++) step(1'b1, 8'h80, "R6");
    step(1'b1, 8'h06, "R6"); idle(2, "R6");
    // R7: upper bits of the select byte are dropped
    step(1'b1, 8'h80, "R7"); step(1'b1, 8'h7C, "R7"); idle(2, "R2");
    // R1 + R10: strap active, then load zero
    doReset(1'b1);
    idle(2, "R1");
    step(1'b1, 8'h80, "R10"); idle(1, "R10"); step(1'b1, 8'h00, "R10"); idle(3, "R10");
    step(1'b1, 8'h80, "R10"); step(1'b1, 8'h0B, "R10"); idle(2, "R2");
    @(negedge clk);
    check("R2");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule